// File: doc/BRIEF.md
# Instruction TLB Replacement Controller

This block decides which of the four entries of a fully associative instruction TLB gets overwritten when a translation must be copied over from the unified TLB. It holds a six-bit pairwise-order matrix. Each bit records, for one pair of entries, which of the two was touched more recently. A fixed pattern decode over the matrix names the least recently used entry. A hit on entry k, or a refill into it, rewrites the three bits that pair k with the other entries, so k becomes the most recent entry.

The same control word also holds the replacement counter for the unified TLB and a boundary for that counter. The counter advances on every unified-TLB access. It returns to zero when it passes a non-zero boundary, or when it passes the last table index. Software can write the whole control word. A write replaces the matrix, the counter and the boundary, and it wins over any hardware update in the same cycle. The TLB arrays themselves lie outside the block.

Top module: `itlb_repl_ctrl`

## Requirements
- R1: After reset, ctrl_o reads 0, victim_o reads 3 and state_err_o reads 0.
- R2: The matrix lives in ctrl_o[31:26]. The decode gives victim 0 when bits 31,30,29 are all 1. It gives victim 1 when bit 31 is 0 and bits 28,27 are 1. It gives victim 2 when bits 30,28 are 0 and bit 26 is 1. It gives victim 3 when bits 29,27,26 are all 0.
- R3: A matrix that fits none of the four patterns drives state_err_o high and victim_o to 0.
- R4: A use strobe on entry k changes only three matrix bits, one clock later. Entry 0 clears bits 31,30,29. Entry 1 sets bit 31 and clears bits 28,27. Entry 2 sets bits 30,28 and clears bit 26. Entry 3 sets bits 29,27,26.
- R5: A refill request updates the matrix as a use of the entry victim_o shows in that cycle. If a use strobe arrives in the same cycle, the refill takes priority over it.
- R6: The counter in ctrl_o[15:10] increments by one on each unified-TLB access strobe.
- R7: When the boundary in ctrl_o[23:18] is non-zero, an access that would carry the counter past the boundary sets the counter to 0.
- R8: When the boundary is 0, the counter goes from 63 back to 0.
- R9: A register write loads bits 31:26, 23:18 and 15:10 from wr_data_i. All other bits of ctrl_o always read 0.
- R10: A register write takes priority over a use, a refill and an access strobe in the same cycle.
- R11: With no strobe and no write, ctrl_o holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| use_i | input | 1 | Instruction TLB entry used |
| use_idx_i | input | 2 | Index of the used entry |
| refill_i | input | 1 | Victim is being refilled this cycle |
| utlb_acc_i | input | 1 | Unified TLB access strobe |
| wr_en_i | input | 1 | Control register write enable |
| wr_data_i | input | 32 | Control register write data |
| ctrl_o | output | 32 | Control register contents |
| victim_o | output | 2 | Entry chosen for replacement |
| state_err_o | output | 1 | Matrix matches no victim pattern |

## Verification
The bench replays a use-and-refill sequence and checks the matrix after every step, so a swapped bit in any touch mask shows up as a wrong victim or a wrong state. It loads an illegal matrix and expects the error flag to rise with victim 0. A design that treated illegal states as legal would point at a random entry without any flag. The counter tests cover the wrap just past a small boundary, which catches an off-by-one that wraps one access too early or too late, and the 63-to-0 wrap with no boundary set. Same-cycle collisions cover a refill against a use, and a write against every strobe. A design with the wrong priority would let the strobe's update leak into the state.

// File: rtl/itlb_repl_pkg.sv
package itlb_repl_pkg;
  localparam int unsigned CTRL_W  = 32;
  localparam int unsigned WAYS    = 4;
  localparam int unsigned WAY_W   = $clog2(WAYS);
  localparam int unsigned MAT_W   = WAYS * (WAYS - 1) / 2;
  localparam int unsigned MAT_LSB = 26;
  localparam int unsigned URB_LSB = 18;
  localparam int unsigned URC_LSB = 10;

  // matrix bit j: 5=(0,1) 4=(0,2) 3=(0,3) 2=(1,2) 1=(1,3) 0=(2,3)
  function automatic logic [MAT_W-1:0] way_mask(input int unsigned w);
    case (w)
      0:       way_mask = 6'b111000;
      1:       way_mask = 6'b100110;
      2:       way_mask = 6'b010101;
      default: way_mask = 6'b001011;
    endcase
  endfunction

  // value that marks way w as least recent
  function automatic logic [MAT_W-1:0] way_lru_val(input int unsigned w);
    case (w)
      0:       way_lru_val = 6'b111000;
      1:       way_lru_val = 6'b000110;
      2:       way_lru_val = 6'b000001;
      default: way_lru_val = 6'b000000;
    endcase
  endfunction

  // touching w writes the inverse of its lru value into its own bits
  function automatic logic [MAT_W-1:0] touch(input logic [MAT_W-1:0] s,
                                             input logic [WAY_W-1:0] w);
    logic [MAT_W-1:0] m;
    m = way_mask(int'(w));
    touch = (s & ~m) | (~way_lru_val(int'(w)) & m);
  endfunction
endpackage

// File: rtl/itlb_lru_matrix.sv
module itlb_lru_matrix
  import itlb_repl_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             use_i,
  input  logic [WAY_W-1:0] use_idx_i,
  input  logic             refill_i,
  input  logic             wr_en_i,
  input  logic [MAT_W-1:0] wr_mat_i,
  output logic [MAT_W-1:0] mat_o,
  output logic [WAY_W-1:0] victim_o,
  output logic             err_o
);
  logic [MAT_W-1:0] mat_q, mat_d;
  logic [WAYS-1:0]  hit;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign hit[w] = (mat_q & way_mask(w)) == way_lru_val(w);
  end

  always_comb begin
    victim_o = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (hit[w]) victim_o = WAY_W'(w);
    end
  end

  assign err_o = ~|hit;

  always_comb begin
    mat_d = mat_q;
    if (wr_en_i)       mat_d = wr_mat_i;
    else if (refill_i) mat_d = touch(mat_q, victim_o);
    else if (use_i)    mat_d = touch(mat_q, use_idx_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mat_q <= '0;
    else         mat_q <= mat_d;
  end

  assign mat_o = mat_q;
endmodule

// File: rtl/utlb_repl_cnt.sv
module utlb_repl_cnt #(
  parameter int unsigned ENTRIES = 64,
  localparam int unsigned CNT_W  = $clog2(ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             acc_i,
  input  logic             wr_en_i,
  input  logic [CNT_W-1:0] wr_cnt_i,
  input  logic [CNT_W-1:0] wr_bnd_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] bnd_o
);
  localparam logic [CNT_W:0] LAST = (CNT_W+1)'(ENTRIES - 1);

  logic [CNT_W-1:0] cnt_q, bnd_q;
  logic [CNT_W:0]   inc;
  logic             wrap;

  assign inc  = {1'b0, cnt_q} + 1'b1;
  assign wrap = ((bnd_q != '0) && (inc > {1'b0, bnd_q})) || (inc > LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      bnd_q <= '0;
    end else if (wr_en_i) begin
      cnt_q <= wr_cnt_i;
      bnd_q <= wr_bnd_i;
    end else if (acc_i) begin
      cnt_q <= wrap ? '0 : inc[CNT_W-1:0];
    end
  end

  assign cnt_o = cnt_q;
  assign bnd_o = bnd_q;
endmodule

// File: rtl/itlb_repl_ctrl.sv
module itlb_repl_ctrl
  import itlb_repl_pkg::*;
#(
  parameter int unsigned UTLB_ENTRIES = 64,
  localparam int unsigned CNT_W = $clog2(UTLB_ENTRIES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              use_i,
  input  logic [WAY_W-1:0]  use_idx_i,
  input  logic              refill_i,
  input  logic              utlb_acc_i,
  input  logic              wr_en_i,
  input  logic [CTRL_W-1:0] wr_data_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic [WAY_W-1:0]  victim_o,
  output logic              state_err_o
);
  logic [MAT_W-1:0] mat;
  logic [CNT_W-1:0] cnt, bnd;

  itlb_lru_matrix i_matrix (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .use_i     (use_i),
    .use_idx_i (use_idx_i),
    .refill_i  (refill_i),
    .wr_en_i   (wr_en_i),
    .wr_mat_i  (wr_data_i[MAT_LSB +: MAT_W]),
    .mat_o     (mat),
    .victim_o  (victim_o),
    .err_o     (state_err_o)
  );

  utlb_repl_cnt #(.ENTRIES(UTLB_ENTRIES)) i_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .acc_i    (utlb_acc_i),
    .wr_en_i  (wr_en_i),
    .wr_cnt_i (wr_data_i[URC_LSB +: CNT_W]),
    .wr_bnd_i (wr_data_i[URB_LSB +: CNT_W]),
    .cnt_o    (cnt),
    .bnd_o    (bnd)
  );

  always_comb begin
    ctrl_o = '0;
    ctrl_o[MAT_LSB +: MAT_W] = mat;
    ctrl_o[URB_LSB +: CNT_W] = bnd;
    ctrl_o[URC_LSB +: CNT_W] = cnt;
  end
endmodule

// File: rtl/itlb_repl_ctrl_chk.sv
module itlb_repl_ctrl_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        use_i,
  input logic [1:0]  use_idx_i,
  input logic        refill_i,
  input logic        utlb_acc_i,
  input logic        wr_en_i,
  input logic [31:0] wr_data_i,
  input logic [31:0] ctrl_o,
  input logic [1:0]  victim_o,
  input logic        state_err_o
);
  localparam logic [31:0] FIELDS = 32'hFCFC_FC00;
  logic [5:0] urc, urb;
  assign urc = ctrl_o[15:10];
  assign urb = ctrl_o[23:18];

  assert_used_not_victim_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    use_i && !refill_i && !wr_en_i && !state_err_o |=> victim_o != $past(use_idx_i));

  assert_refill_moves_victim_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    refill_i && !wr_en_i && !state_err_o |=> victim_o != $past(victim_o));

  assert_cnt_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    utlb_acc_i && !wr_en_i && ((urb == 6'd0) ? (urc != 6'd63) : (urc < urb))
    |=> urc == $past(urc) + 6'd1);

  assert_cnt_wrap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    utlb_acc_i && !wr_en_i && urb != 6'd0 && urc >= urb |=> urc == 6'd0);

  assert_write_wins_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> ctrl_o == ($past(wr_data_i) & FIELDS));

  assert_idle_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !use_i && !refill_i && !utlb_acc_i && !wr_en_i |=> $stable(ctrl_o));
endmodule

bind itlb_repl_ctrl itlb_repl_ctrl_chk i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .use_i       (use_i),
  .use_idx_i   (use_idx_i),
  .refill_i    (refill_i),
  .utlb_acc_i  (utlb_acc_i),
  .wr_en_i     (wr_en_i),
  .wr_data_i   (wr_data_i),
  .ctrl_o      (ctrl_o),
  .victim_o    (victim_o),
  .state_err_o (state_err_o)
);

// File: tb/test_itlb_repl_ctrl.sv
`timescale 1ns/1ps
module test_itlb_repl_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        use_s = 1'b0;
  logic [1:0]  use_idx = '0;
  logic        refill = 1'b0;
  logic        acc = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] ctrl;
  logic [1:0]  victim;
  logic        err;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  itlb_repl_ctrl i_itlb_repl_ctrl (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .use_i       (use_s),
    .use_idx_i   (use_idx),
    .refill_i    (refill),
    .utlb_acc_i  (acc),
    .wr_en_i     (wr_en),
    .wr_data_i   (wr_data),
    .ctrl_o      (ctrl),
    .victim_o    (victim),
    .state_err_o (err)
  );

  // {refill, idx[1:0], expected matrix[5:0], expected victim[1:0]}
  localparam int NV = 9;
  localparam logic [10:0] VEC [NV] = '{
    {1'b0, 2'd3, 6'b001011, 2'd2},
    {1'b0, 2'd2, 6'b011110, 2'd1},
    {1'b0, 2'd1, 6'b111000, 2'd0},
    {1'b0, 2'd0, 6'b000000, 2'd3},
    {1'b1, 2'd0, 6'b001011, 2'd2},
    {1'b1, 2'd0, 6'b011110, 2'd1},
    {1'b0, 2'd0, 6'b000110, 2'd1},
    {1'b0, 2'd3, 6'b001111, 2'd1},
    {1'b1, 2'd0, 6'b101001, 2'd2}
  };

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // drive after a falling edge; one rising edge; outputs read at next falling edge
  task automatic cycle();
    @(negedge clk);
    use_s = 1'b0; refill = 1'b0; acc = 1'b0; wr_en = 1'b0;
  endtask

  task automatic write(input logic [31:0] d);
    wr_en = 1'b1; wr_data = d;
    cycle();
  endtask

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    repeat (2) @(negedge clk);
    check(ctrl, 32'h0, "R1 ctrl reset");
    check({30'd0, victim}, 32'd3, "R1 victim reset");
    check({31'd0, err}, 32'd0, "R1 err reset");
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      refill = VEC[i][10];
      use_s = ~VEC[i][10];
      use_idx = VEC[i][9:8];
      cycle();
      check({26'd0, ctrl[31:26]}, {26'd0, VEC[i][7:2]},
            VEC[i][10] ? "R5 refill matrix" : "R4 use matrix");
      check({30'd0, victim}, {30'd0, VEC[i][1:0]}, "R2 victim decode");
    end

    // R11 idle hold
    cycle();
    check(ctrl, 32'hA400_0000, "R11 idle hold");

    // R5 refill beats use in the same cycle
    write(32'h0);
    refill = 1'b1; use_s = 1'b1; use_idx = 2'd0;
    cycle();
    check({26'd0, ctrl[31:26]}, 32'b001011, "R5 refill priority");

    // R3 illegal matrix 010001
    write(32'h4400_0000);
    check({31'd0, err}, 32'd1, "R3 err flag");
    check({30'd0, victim}, 32'd0, "R3 victim on illegal");

    // R9 write loads fields, other bits zero
    write(32'hFFFF_FFFF);
    check(ctrl, 32'hFCFC_FC00, "R9 field mask");

    // R6/R7 boundary 3
    write(32'h000C_0000);
    for (int i = 1; i <= 3; i++) begin
      acc = 1'b1;
      cycle();
      check({26'd0, ctrl[15:10]}, i, "R6 count step");
    end
    acc = 1'b1;
    cycle();
    check({26'd0, ctrl[15:10]}, 32'd0, "R7 wrap past boundary");

    // R8 no boundary, 62 -> 63 -> 0
    write(32'h0000_F800);
    acc = 1'b1;
    cycle();
    check({26'd0, ctrl[15:10]}, 32'd63, "R8 count to 63");
    acc = 1'b1;
    cycle();
    check({26'd0, ctrl[15:10]}, 32'd0, "R8 wrap at 63");

    // R10 write wins over every strobe
    acc = 1'b1; use_s = 1'b1; use_idx = 2'd1; refill = 1'b1;
    write(32'hE008_1400);
    check(ctrl, 32'hE008_1400, "R10 write priority");
    check({30'd0, victim}, 32'd0, "R10 victim after write");

    finish_run();
  end
endmodule